// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of one interrupt controller. It watches a byte-wide I/O write port, with an address, a data byte and a write strobe. From those writes it recognises the four-byte initialization sequence and stores the vector base, the cascade setup and the auto end-of-interrupt mode. After the sequence it holds the interrupt mask register. Priority resolution and acknowledge handling live elsewhere in the controller. They consume the configuration values this block exports.

A controller instance is built either as the primary controller, decoding ports 20h and 21h, or as the secondary controller, decoding ports A0h and A1h.

A write of a byte with bit 4 set to the lower port (the command port) opens a new sequence at any moment. That opening write also applies a fixed set of side effects to the controller state. The next three writes to the upper port (the data port) complete the sequence. From then on, data-port writes load the mask.

Top module: `pic_init_seq`

## Requirements
- R1: After reset the outputs are: `cfg_ready`=0, `irq_mask`=FFh, `rd_req_sel`=0, `slave_id`=0, `lowest_prio`=0, `vec_base`=0, `cascade_map`=0, `auto_eoi`=0 and `rearm_edges`=0.
- R2: A command-port write restarts the sequence from any state, including the middle of a sequence and the ready state, and drops `cfg_ready`, when both of these hold:
  - the address is 20h on the primary controller (parameter IS_SLAVE=0) or A0h on the secondary controller (IS_SLAVE=1);
  - data bit 4 is 1.
- R3: The sequence-opening write clears `irq_mask` to 00h.
- R4: The sequence-opening write sets `slave_id` to 7 and `lowest_prio` to 7, and sets `rd_req_sel` to 1, which selects the request register for status reads.
- R5: `rearm_edges` is high for exactly the one cycle after each sequence-opening write, and is low otherwise.
- R6: After the opening write, the next three data-port writes (21h or A1h) are taken in order as the second, third and fourth command words. The second word's bits 7:3 are stored in `vec_base`.
- R7: The third word is handled by controller type:
  - on the primary controller it is stored whole in `cascade_map`;
  - on the secondary controller its bits 2:0 are stored in `slave_id`, and `cascade_map` stays 0.
- R8: Bit 1 of the fourth word is stored in `auto_eoi`, and `cfg_ready` rises in the cycle after the fourth word.
- R9: While `cfg_ready` is 1, each data-port write loads `irq_mask` with the data byte.
- R10: All of the following leave every output unchanged, apart from the command-word capture described in R6 to R8:
  - data-port writes before any sequence or during a sequence never change `irq_mask`;
  - command-port writes with bit 4 at 0 are ignored;
  - writes to other addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | I/O write address |
| wr_data | input | DATA_W | I/O write data byte |
| rearm_edges | output | 1 | One-cycle pulse: input edge detectors discard latched state |
| cfg_ready | output | 1 | Initialization sequence completed |
| irq_mask | output | DATA_W | Interrupt mask register |
| vec_base | output | DATA_W-3 | Vector base from the second command word |
| cascade_map | output | DATA_W | Cascade input bitmap (primary controller) |
| slave_id | output | ID_W | Secondary-controller address |
| auto_eoi | output | 1 | Auto end-of-interrupt enable |
| rd_req_sel | output | 1 | Status read targets the request register |
| lowest_prio | output | ID_W | Input that holds the lowest priority |

## Verification
Some properties hold on every cycle, and the in-module assertions check these:
- the opening write always leads to the second-word state;
- it always clears the mask, loads the fixed defaults and produces a single-cycle rearm pulse;
- the mask never moves outside the ready state except through an opening write;
- ready can only be entered from the fourth-word state.

Other behaviour depends on the order of writes, and only the bench scenarios show it:
- which data-port byte lands in which field;
- a restart in the middle of a sequence discarding the partial sequence;
- the primary and secondary instances reacting only to their own ports while sharing one write bus;
- ignored writes leaving every output untouched.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_ICW2   = 3'd1,
    ST_ICW3   = 3'd2,
    ST_ICW4   = 3'd3,
    ST_READY  = 3'd4
  } seq_state_t;

  localparam int OPEN_FLAG_BIT = 4;
  localparam int AEOI_BIT      = 1;
  localparam int VBASE_LSB     = 3;
endpackage

// File: rtl/pic_port_decode.sv
module pic_port_decode #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h20
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              open_hit,
  output logic              data_hit
);
  import pic_init_pkg::*;

  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  always_comb begin
    open_hit = wr_en && (wr_addr == BASE_ADDR) && wr_data[OPEN_FLAG_BIT];
    data_hit = wr_en && (wr_addr == DATA_ADDR);
  end
endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic open_hit,
  input  logic data_hit,
  output logic take_w2,
  output logic take_w3,
  output logic take_w4,
  output logic mask_wr,
  output logic seq_ready
);
  import pic_init_pkg::*;

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (open_hit) begin
      state_d = ST_ICW2;
    end else if (data_hit) begin
      case (state_q)
        ST_ICW2: state_d = ST_ICW3;
        ST_ICW3: state_d = ST_ICW4;
        ST_ICW4: state_d = ST_READY;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_UNINIT;
    else        state_q <= state_d;
  end

  always_comb begin
    take_w2   = data_hit && !open_hit && (state_q == ST_ICW2);
    take_w3   = data_hit && !open_hit && (state_q == ST_ICW3);
    take_w4   = data_hit && !open_hit && (state_q == ST_ICW4);
    mask_wr   = data_hit && !open_hit && (state_q == ST_READY);
    seq_ready = (state_q == ST_READY);
  end

  // R2: an opening write always leads to the second-word state
  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> (state_q == ST_ICW2));

  // R8: ready can only be entered from the fourth-word state
  p_ready_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_ready) |-> ($past(state_q) == ST_ICW4));
endmodule

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs #(
  parameter int DATA_W   = 8,
  parameter bit IS_SLAVE = 1'b0,
  parameter int ID_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_hit,
  input  logic              take_w2,
  input  logic              take_w3,
  input  logic              take_w4,
  input  logic              mask_wr,
  input  logic              seq_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rearm_edges,
  output logic [DATA_W-1:0] irq_mask,
  output logic [DATA_W-4:0] vec_base,
  output logic [DATA_W-1:0] cascade_map,
  output logic [ID_W-1:0]   slave_id,
  output logic              auto_eoi,
  output logic              rd_req_sel,
  output logic [ID_W-1:0]   lowest_prio
);
  import pic_init_pkg::*;

  localparam logic [ID_W-1:0] ID_MAX = {ID_W{1'b1}};

  logic              rearm_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-4:0] vbase_q;
  logic              aeoi_q;
  logic              rdsel_q;
  logic [ID_W-1:0]   lowp_q;
  logic [ID_W-1:0]   sid_q;
  logic [ID_W-1:0]   sid_d;
  logic              sid_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rearm_q <= 1'b0;
    else        rearm_q <= open_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             mask_q <= '1;
    else if (open_hit)      mask_q <= '0;
    else if (mask_wr)       mask_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             vbase_q <= '0;
    else if (take_w2)       vbase_q <= wr_data[DATA_W-1:VBASE_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             aeoi_q <= 1'b0;
    else if (take_w4)       aeoi_q <= wr_data[AEOI_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdsel_q <= 1'b0;
      lowp_q  <= '0;
    end else if (open_hit) begin
      rdsel_q <= 1'b1;
      lowp_q  <= ID_MAX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sid_q <= '0;
    else if (sid_en) sid_q <= sid_d;
  end

  generate
    if (IS_SLAVE) begin : g_slave
      always_comb begin
        sid_en = open_hit || take_w3;
        sid_d  = open_hit ? ID_MAX : wr_data[ID_W-1:0];
      end
      assign cascade_map = '0;
    end else begin : g_master
      logic [DATA_W-1:0] casc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       casc_q <= '0;
        else if (take_w3) casc_q <= wr_data;
      end
      always_comb begin
        sid_en = open_hit;
        sid_d  = ID_MAX;
      end
      assign cascade_map = casc_q;
    end
  endgenerate

  assign rearm_edges = rearm_q;
  assign irq_mask    = mask_q;
  assign vec_base    = vbase_q;
  assign slave_id    = sid_q;
  assign auto_eoi    = aeoi_q;
  assign rd_req_sel  = rdsel_q;
  assign lowest_prio = lowp_q;

  // R3: the opening write clears the mask
  p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> (irq_mask == '0));

  // R10: outside the ready state only an opening write moves the mask
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_ready && !open_hit) |=> $stable(irq_mask));

  // R4: fixed defaults follow every opening write
  p_init_defaults_r4: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> (slave_id == ID_MAX && rd_req_sel && lowest_prio == ID_MAX));

  // R5: the rearm pulse follows an opening write
  p_rearm_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    open_hit |=> rearm_edges);

  // R5: no rearm pulse without an opening write
  p_rearm_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !open_hit |=> !rearm_edges);
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq #(
  parameter bit IS_SLAVE = 1'b0,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  output logic                      rearm_edges,
  output logic                      cfg_ready,
  output logic [DATA_W-1:0]         irq_mask,
  output logic [DATA_W-4:0]         vec_base,
  output logic [DATA_W-1:0]         cascade_map,
  output logic [$clog2(DATA_W)-1:0] slave_id,
  output logic                      auto_eoi,
  output logic                      rd_req_sel,
  output logic [$clog2(DATA_W)-1:0] lowest_prio
);
  localparam int ID_W = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] BASE_ADDR = IS_SLAVE ? ADDR_W'(8'hA0) : ADDR_W'(8'h20);

  logic rst_meta_q, rst_sync_q;
  logic open_hit, data_hit;
  logic take_w2, take_w3, take_w4, mask_wr, seq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pic_port_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .open_hit(open_hit), .data_hit(data_hit)
  );

  pic_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .open_hit(open_hit), .data_hit(data_hit),
    .take_w2(take_w2), .take_w3(take_w3), .take_w4(take_w4),
    .mask_wr(mask_wr), .seq_ready(seq_ready)
  );

  pic_cfg_regs #(
    .DATA_W(DATA_W), .IS_SLAVE(IS_SLAVE), .ID_W(ID_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_q),
    .open_hit(open_hit), .take_w2(take_w2), .take_w3(take_w3),
    .take_w4(take_w4), .mask_wr(mask_wr), .seq_ready(seq_ready),
    .wr_data(wr_data),
    .rearm_edges(rearm_edges), .irq_mask(irq_mask), .vec_base(vec_base),
    .cascade_map(cascade_map), .slave_id(slave_id), .auto_eoi(auto_eoi),
    .rd_req_sel(rd_req_sel), .lowest_prio(lowest_prio)
  );

  assign cfg_ready = seq_ready;
endmodule

// File: tb/pic_init_seq_tb.sv
module pic_init_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  logic       m_rearm, m_ready, m_aeoi, m_rdsel;
  logic [7:0] m_mask, m_casc;
  logic [4:0] m_vbase;
  logic [2:0] m_sid, m_lowp;
  logic       s_rearm, s_ready, s_aeoi, s_rdsel;
  logic [7:0] s_mask, s_casc;
  logic [4:0] s_vbase;
  logic [2:0] s_sid, s_lowp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_init_seq #(.IS_SLAVE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rearm_edges(m_rearm), .cfg_ready(m_ready), .irq_mask(m_mask), .vec_base(m_vbase),
    .cascade_map(m_casc), .slave_id(m_sid), .auto_eoi(m_aeoi), .rd_req_sel(m_rdsel),
    .lowest_prio(m_lowp)
  );

  pic_init_seq #(.IS_SLAVE(1'b1)) dut_slv_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rearm_edges(s_rearm), .cfg_ready(s_ready), .irq_mask(s_mask), .vec_base(s_vbase),
    .cascade_map(s_casc), .slave_id(s_sid), .auto_eoi(s_aeoi), .rd_req_sel(s_rdsel),
    .lowest_prio(s_lowp)
  );

  // Reference model, index 0 = primary, 1 = secondary
  int         md_st   [2];
  logic [7:0] md_mask [2];
  logic [4:0] md_vbase[2];
  logic [7:0] md_casc [2];
  logic [2:0] md_sid  [2];
  logic       md_aeoi [2];
  logic       md_rdsel[2];
  logic [2:0] md_lowp [2];
  logic       md_rearm[2];

  logic [61:0] exp_q[$];
  string       tag_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  function automatic logic [30:0] snap(int i);
    return {(md_st[i] == 4), md_mask[i], md_vbase[i], md_casc[i], md_sid[i],
            md_aeoi[i], md_rdsel[i], md_lowp[i], md_rearm[i]};
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      md_st[i] = 0; md_mask[i] = 8'hFF; md_vbase[i] = '0; md_casc[i] = '0;
      md_sid[i] = '0; md_aeoi[i] = 1'b0; md_rdsel[i] = 1'b0; md_lowp[i] = '0;
      md_rearm[i] = 1'b0;
    end
  endfunction

  function automatic void model_apply(bit valid, logic [7:0] a, logic [7:0] d);
    for (int i = 0; i < 2; i++) begin
      logic [7:0] base;
      base = (i == 0) ? 8'h20 : 8'hA0;
      md_rearm[i] = 1'b0;
      if (valid && a == base && d[4]) begin
        md_st[i] = 1; md_mask[i] = 8'h00; md_sid[i] = 3'd7;
        md_rdsel[i] = 1'b1; md_lowp[i] = 3'd7; md_rearm[i] = 1'b1;
      end else if (valid && a == base + 8'd1) begin
        case (md_st[i])
          1: begin md_vbase[i] = d[7:3]; md_st[i] = 2; end
          2: begin
               if (i == 0) md_casc[i] = d;
               else        md_sid[i]  = d[2:0];
               md_st[i] = 3;
             end
          3: begin md_aeoi[i] = d[1]; md_st[i] = 4; end
          4: md_mask[i] = d;
          default: ;
        endcase
      end
    end
  endfunction

  task automatic push_exp(string tag);
    exp_q.push_back({snap(1), snap(0)});
    tag_q.push_back(tag);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_apply(1'b1, a, d);
    push_exp(tag);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    @(posedge clk);
    #1;
    model_apply(1'b0, 8'h00, 8'h00);
    push_exp(tag);
  endtask

  // Monitor: compares the design against the queued expectations
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [61:0] act, exp_v;
      string t;
      act = {s_ready, s_mask, s_vbase, s_casc, s_sid, s_aeoi, s_rdsel, s_lowp, s_rearm,
             m_ready, m_mask, m_vbase, m_casc, m_sid, m_aeoi, m_rdsel, m_lowp, m_rearm};
      exp_v = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (act !== exp_v) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, act, exp_v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    push_exp("R1 reset state");

    wr(8'h21, 8'h55, "R10 data write before init ignored");
    wr(8'h20, 8'h0C, "R10 base write without bit4 ignored");
    wr(8'h20, 8'h11, "R2 R3 R4 R5 primary opening write");
    idle("R5 rearm lasts one cycle");
    wr(8'h21, 8'h48, "R6 vector base, R10 mask held in sequence");
    wr(8'h21, 8'h04, "R7 primary cascade map");
    wr(8'h21, 8'h03, "R8 auto eoi and ready");
    wr(8'h21, 8'hA5, "R9 primary mask load");
    wr(8'h22, 8'h00, "R10 foreign address ignored");
    wr(8'hA0, 8'h10, "R2 R4 secondary opening write, primary untouched");
    wr(8'hA1, 8'h70, "R6 secondary vector base");
    wr(8'hA1, 8'h02, "R7 secondary id");
    wr(8'hA1, 8'h01, "R8 secondary auto eoi off, ready");
    wr(8'hA1, 8'h3C, "R9 secondary mask load");
    wr(8'h20, 8'h13, "R2 R3 restart from ready");
    wr(8'h21, 8'h20, "R6 partial sequence");
    wr(8'h20, 8'h10, "R2 restart mid-sequence");
    wr(8'h21, 8'hF8, "R6 restarted vector base");
    wr(8'h21, 8'h80, "R7 restarted cascade");
    wr(8'h21, 8'h02, "R8 restarted ready");
    wr(8'h21, 8'h00, "R9 mask cleared by write");
    wr(8'hA0, 8'h07, "R10 secondary base without bit4 ignored");
    idle("R5 no rearm when idle");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule